// File: doc/BRIEF.md
# Paged DMA Address Translator

This block converts the I/O addresses issued by DMA-capable devices into system addresses by looking them up in an on-chip table of 64-bit translation entries. A requester presents an I/O address together with its intent (read or write). One clock later the block returns four things: the page-aligned I/O base, the translated page address, the mask that selects the byte offset within the page, and the two-bit access code stored in the entry. A fault flag is raised whenever the access cannot proceed.

Two configuration values set the page size (as a shift) and the number of table entries in use. Together they define the translation window, whose size the block reports. The table sits in a synchronous RAM inside the block, and a simple one-entry-per-cycle write port loads it. Reset makes every entry read as zero, so every page faults until software loads the table.

Top module: `dxl_translate`

## Requirements
- R1: A lookup presented with `req_valid` high produces its result with `rsp_valid` high exactly one clock later. When `rsp_valid` is low, every result output is zero.
- R2: The table index is `req_addr` shifted right by the configured page shift. A lookup is in range only when this index is strictly less than the configured entry count.
- R3: For an in-range lookup, `rsp_iova` is `req_addr` with its low `shift` bits cleared, and `rsp_xaddr` is the stored entry with its low `shift` bits cleared.
- R4: For an in-range lookup, `rsp_mask` equals 2^shift − 1.
- R5: For an out-of-range lookup, `rsp_iova` and `rsp_xaddr` are zero, `rsp_mask` is all ones, `rsp_perm` is 0 and `rsp_fault` is 1.
- R6: For an in-range lookup, `rsp_perm` returns entry bits [1:0]. The codes are 0 = no access, 1 = read only, 2 = write only, 3 = read and write.
- R7: `rsp_fault` is 1 exactly when the result is valid and one of these holds: the lookup is out of range, the code is 0, a write hits code 1, or a read hits code 2.
- R8: After reset the page shift is 12 and the entry count is the full table depth. A `cfg_wr` pulse loads both values, and lookups from the next cycle on use them. A count above the table depth is stored as the table depth.
- R9: `win_size` always equals the stored entry count shifted left by the stored page shift.
- R10: Reset makes every table entry read as zero, including entries written before the reset.
- R11: A table write in the same cycle as a lookup of the same index returns the old contents to that lookup. Lookups issued from the next cycle on see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load page shift and entry count |
| cfg_shift_in | input | SHIFT_W | New page shift |
| cfg_count_in | input | IDX_W+1 | New entry count |
| tw_en | input | 1 | Table write enable |
| tw_idx | input | IDX_W | Table write index |
| tw_data | input | ENTRY_W | Table write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | I/O address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| win_size | output | ENTRY_W | Window size in bytes |
| rsp_valid | output | 1 | Result strobe |
| rsp_iova | output | ADDR_W | Page-aligned I/O base |
| rsp_xaddr | output | ENTRY_W | Translated page address |
| rsp_mask | output | ENTRY_W | In-page offset mask |
| rsp_perm | output | 2 | Access code of the entry |
| rsp_fault | output | 1 | Access denied |

## Verification
A wrong index or range decision shows up on the very next result as a wrong mask class: all ones where a page mask was due, or the reverse, together with a wrong fault flag. A stale or uncleared entry shows up as nonzero `rsp_xaddr` or `rsp_perm` on the first lookup of that page after reset or after a write. A bad page-shift register is visible at once on `win_size` and on the next mask. The sweeps cover every index across several shifts and counts, with both intents, so each such defect appears within a few lookups.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

   typedef enum logic [1:0] {
      PERM_NONE = 2'd0,
      PERM_RD   = 2'd1,
      PERM_WR   = 2'd2,
      PERM_RW   = 2'd3
   } perm_e;

   // true when an access of the given intent is allowed by the code
   function automatic logic perm_allows(input logic [1:0] code, input logic is_write);
      case (perm_e'(code))
         PERM_RD: perm_allows = !is_write;
         PERM_WR: perm_allows = is_write;
         PERM_RW: perm_allows = 1'b1;
         default: perm_allows = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dxl_cfg_regs.sv
module dxl_cfg_regs #(
   parameter int IDX_W     = 6,
   parameter int SHIFT_W   = 6,
   parameter int DEF_SHIFT = 12,
   parameter int ENTRY_W   = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [SHIFT_W-1:0] cfg_shift_in,
   input  logic [IDX_W:0]     cfg_count_in,
   output logic [SHIFT_W-1:0] cur_shift,
   output logic [IDX_W:0]     cur_count,
   output logic [ENTRY_W-1:0] win_size
);
   localparam int CNT_W = IDX_W + 1;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1 << IDX_W);

   logic [CNT_W-1:0] count_clamped;

   always_comb begin
      count_clamped = (cfg_count_in > FULL_CNT) ? FULL_CNT : cfg_count_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_shift <= SHIFT_W'(DEF_SHIFT);
         cur_count <= FULL_CNT;
      end else if (cfg_wr) begin
         cur_shift <= cfg_shift_in;
         cur_count <= count_clamped;
      end
   end

   assign win_size = ENTRY_W'(cur_count) << cur_shift;

endmodule

// File: rtl/dxl_index.sv
module dxl_index #(
   parameter int ADDR_W  = 32,
   parameter int ENTRY_W = 64,
   parameter int IDX_W   = 6,
   parameter int SHIFT_W = 6
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [SHIFT_W-1:0] shift,
   input  logic [IDX_W:0]     count,
   output logic [IDX_W-1:0]   ram_idx,
   output logic               in_range,
   output logic [ADDR_W-1:0]  page_base,
   output logic [ENTRY_W-1:0] page_mask
);
   logic [ADDR_W-1:0] idx_full;

   always_comb begin
      idx_full  = addr >> shift;
      in_range  = idx_full < ADDR_W'(count);
      ram_idx   = idx_full[IDX_W-1:0];
      page_mask = (ENTRY_W'(1) << shift) - ENTRY_W'(1);
      page_base = addr & ~page_mask[ADDR_W-1:0];
   end

endmodule

// File: rtl/dxl_table_ram.sv
module dxl_table_ram #(
   parameter int IDX_W   = 6,
   parameter int ENTRY_W = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic               rd_en,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ENTRY_W-1:0] rd_data
);
   localparam int DEPTH = 1 << IDX_W;

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]   live;
   logic [ENTRY_W-1:0] raw_q;
   logic               live_q;

   // storage without reset; read-before-write on a shared index
   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
      if (rd_en) raw_q <= mem[rd_idx];
   end

   // one flag per entry: cleared by reset, set by the first write
   for (genvar g = 0; g < DEPTH; g++) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    live[g] <= 1'b0;
         else if (wr_en && (wr_idx == IDX_W'(g)))       live[g] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     live_q <= 1'b0;
      else if (rd_en) live_q <= live[rd_idx];
   end

   assign rd_data = live_q ? raw_q : '0;

endmodule

// File: rtl/dxl_perm_check.sv
module dxl_perm_check (
   input  logic       valid,
   input  logic       in_range,
   input  logic       is_write,
   input  logic [1:0] code,
   output logic       fault
);
   import dxl_pkg::*;

   always_comb begin
      fault = valid && (!in_range || !perm_allows(code, is_write));
   end

endmodule

// File: rtl/dxl_translate.sv
module dxl_translate #(
   parameter int ADDR_W    = 32,
   parameter int ENTRY_W   = 64,
   parameter int IDX_W     = 6,
   parameter int SHIFT_W   = 6,
   parameter int DEF_SHIFT = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [SHIFT_W-1:0] cfg_shift_in,
   input  logic [IDX_W:0]     cfg_count_in,
   input  logic               tw_en,
   input  logic [IDX_W-1:0]   tw_idx,
   input  logic [ENTRY_W-1:0] tw_data,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               req_write,
   output logic [ENTRY_W-1:0] win_size,
   output logic               rsp_valid,
   output logic [ADDR_W-1:0]  rsp_iova,
   output logic [ENTRY_W-1:0] rsp_xaddr,
   output logic [ENTRY_W-1:0] rsp_mask,
   output logic [1:0]         rsp_perm,
   output logic               rsp_fault
);
   localparam int CNT_W = IDX_W + 1;

   if (ADDR_W > ENTRY_W) begin : g_bad_addr
      $error("ADDR_W must not exceed ENTRY_W");
   end
   if ((1 << SHIFT_W) > ENTRY_W) begin : g_bad_shift
      $error("SHIFT_W too wide for ENTRY_W");
   end
   if (DEF_SHIFT >= (1 << SHIFT_W)) begin : g_bad_def
      $error("DEF_SHIFT does not fit SHIFT_W");
   end
   if (CNT_W > ADDR_W) begin : g_bad_idx
      $error("IDX_W too wide for ADDR_W");
   end

   logic [SHIFT_W-1:0] cur_shift;
   logic [CNT_W-1:0]   cur_count;
   logic [IDX_W-1:0]   ram_idx;
   logic               in_range;
   logic [ADDR_W-1:0]  page_base;
   logic [ENTRY_W-1:0] page_mask;
   logic [ENTRY_W-1:0] entry;

   logic               v_q, inr_q, wr_q;
   logic [ADDR_W-1:0]  base_q;
   logic [ENTRY_W-1:0] mask_q;
   logic               fault_w;

   dxl_cfg_regs #(
      .IDX_W(IDX_W), .SHIFT_W(SHIFT_W), .DEF_SHIFT(DEF_SHIFT), .ENTRY_W(ENTRY_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
      .cfg_shift_in(cfg_shift_in), .cfg_count_in(cfg_count_in),
      .cur_shift(cur_shift), .cur_count(cur_count), .win_size(win_size)
   );

   dxl_index #(
      .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .SHIFT_W(SHIFT_W)
   ) u_idx (
      .addr(req_addr), .shift(cur_shift), .count(cur_count),
      .ram_idx(ram_idx), .in_range(in_range),
      .page_base(page_base), .page_mask(page_mask)
   );

   dxl_table_ram #(
      .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)
   ) u_ram (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tw_en), .wr_idx(tw_idx), .wr_data(tw_data),
      .rd_en(req_valid && in_range), .rd_idx(ram_idx),
      .rd_data(entry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         inr_q  <= 1'b0;
         wr_q   <= 1'b0;
         base_q <= '0;
         mask_q <= '0;
      end else begin
         v_q <= req_valid;
         if (req_valid) begin
            inr_q  <= in_range;
            wr_q   <= req_write;
            base_q <= page_base;
            mask_q <= page_mask;
         end
      end
   end

   dxl_perm_check u_perm (
      .valid(v_q), .in_range(inr_q), .is_write(wr_q),
      .code(entry[1:0]), .fault(fault_w)
   );

   always_comb begin
      rsp_valid = v_q;
      rsp_fault = fault_w;
      if (!v_q) begin
         rsp_iova  = '0;
         rsp_xaddr = '0;
         rsp_mask  = '0;
         rsp_perm  = 2'd0;
      end else if (inr_q) begin
         rsp_iova  = base_q;
         rsp_xaddr = entry & ~mask_q;
         rsp_mask  = mask_q;
         rsp_perm  = entry[1:0];
      end else begin
         rsp_iova  = '0;
         rsp_xaddr = '0;
         rsp_mask  = '1;
         rsp_perm  = 2'd0;
      end
   end

endmodule

// File: rtl/dxl_translate_chk.sv
module dxl_translate_chk #(
   parameter int ADDR_W  = 32,
   parameter int ENTRY_W = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               rsp_valid,
   input logic [ADDR_W-1:0]  rsp_iova,
   input logic [ENTRY_W-1:0] rsp_xaddr,
   input logic [ENTRY_W-1:0] rsp_mask,
   input logic [1:0]         rsp_perm,
   input logic               rsp_fault
);
   AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R1
   AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_mask == '0 && rsp_xaddr == '0 && !rsp_fault)); // R1
   AST_ALIGNED_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((rsp_xaddr & rsp_mask) == '0
                     && (rsp_iova & rsp_mask[ADDR_W-1:0]) == '0)); // R3
   AST_MASK_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (((rsp_mask + ENTRY_W'(1)) & rsp_mask) == '0)); // R4
   AST_FULL_MASK_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (&rsp_mask)) |-> (rsp_perm == 2'd0 && rsp_fault
                                       && rsp_xaddr == '0 && rsp_iova == '0)); // R5
   AST_NONE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_perm == 2'd0) |-> rsp_fault); // R7
   AST_RW_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_perm == 2'd3) |-> !rsp_fault); // R7
endmodule

bind dxl_translate dxl_translate_chk #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_chk (.*);

// File: tb/dxl_translate_test.sv
module dxl_translate_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int EW = 64;
   localparam int IW = 3;
   localparam int SW = 6;
   localparam int DEPTH = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [SW-1:0] cfg_shift_in = '0;
   logic [IW:0]   cfg_count_in = '0;
   logic          tw_en = 1'b0;
   logic [IW-1:0] tw_idx = '0;
   logic [EW-1:0] tw_data = '0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic [EW-1:0] win_size;
   logic          rsp_valid;
   logic [AW-1:0] rsp_iova;
   logic [EW-1:0] rsp_xaddr;
   logic [EW-1:0] rsp_mask;
   logic [1:0]    rsp_perm;
   logic          rsp_fault;

   int errs = 0;
   int checks = 0;
   logic [EW-1:0] ent [DEPTH];
   int m_sh = 12;
   int m_cnt = DEPTH;

   always #(CLK_PERIOD/2) clk = ~clk;

   dxl_translate #(.ADDR_W(AW), .ENTRY_W(EW), .IDX_W(IW), .SHIFT_W(SW), .DEF_SHIFT(12)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_shift_in(cfg_shift_in),
      .cfg_count_in(cfg_count_in), .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .win_size(win_size), .rsp_valid(rsp_valid), .rsp_iova(rsp_iova),
      .rsp_xaddr(rsp_xaddr), .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
   );

   task automatic chk(input logic ok, input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_cfg(input int sh, input int cnt);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_shift_in = SW'(sh); cfg_count_in = (IW+1)'(cnt);
      @(negedge clk);
      cfg_wr = 1'b0;
      m_sh = sh;
      m_cnt = (cnt > DEPTH) ? DEPTH : cnt;
   endtask

   task automatic put(input int i, input logic [EW-1:0] d);
      @(negedge clk);
      tw_en = 1'b1; tw_idx = IW'(i); tw_data = d;
      @(negedge clk);
      tw_en = 1'b0;
      ent[i] = d;
   endtask

   // issue one lookup, compare all result fields one cycle later
   task automatic look(input logic [AW-1:0] a, input logic w, input string tag);
      logic [EW-1:0] mask, e, xe;
      logic [AW-1:0] be;
      logic [1:0] pe;
      logic fe, inr;
      int idx;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = w;
      @(negedge clk);
      req_valid = 1'b0;
      idx = int'(a) >> m_sh;
      inr = idx < m_cnt;
      mask = (EW'(1) << m_sh) - 1;
      if (inr) begin
         e  = ent[idx];
         be = a & ~mask[AW-1:0];
         xe = e & ~mask;
         pe = e[1:0];
         fe = (pe == 2'd0) || (w && pe == 2'd1) || (!w && pe == 2'd2);
      end else begin
         be = '0; xe = '0; mask = '1; pe = 2'd0; fe = 1'b1;
      end
      chk(rsp_valid == 1'b1, {tag, " R1 valid"}, EW'(rsp_valid), 1);
      chk(rsp_iova == be, {tag, " R2/R3 iova"}, EW'(rsp_iova), EW'(be));
      chk(rsp_xaddr == xe, {tag, " R3 xaddr"}, rsp_xaddr, xe);
      chk(rsp_mask == mask, {tag, inr ? " R4 mask" : " R5 mask"}, rsp_mask, mask);
      chk(rsp_perm == pe, {tag, " R6 perm"}, EW'(rsp_perm), EW'(pe));
      chk(rsp_fault == fe, {tag, " R7 fault"}, EW'(rsp_fault), EW'(fe));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin : main
      int shs [3];
      int cnts [3];
      shs[0] = 3; shs[1] = 5; shs[2] = 12;
      cnts[0] = 0; cnts[1] = 3; cnts[2] = 8;
      for (int i = 0; i < DEPTH; i++) ent[i] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(rsp_valid == 1'b0, "R1 idle after reset", EW'(rsp_valid), 0);
      chk(win_size == EW'(DEPTH << 12), "R8/R9 default window", win_size, EW'(DEPTH << 12));
      look(16'h1234, 1'b0, "R8 default shift R10 cleared");
      look(16'h7FFF, 1'b1, "R10 cleared top entry");
      @(negedge clk);
      chk(rsp_valid == 1'b0 && rsp_mask == '0, "R1 quiet without request", rsp_mask, 0);

      // load entries, one of each access code
      for (int i = 0; i < DEPTH; i++)
         put(i, (64'hC0DE_0000_0000_0000 ^ (EW'(i) * 64'h0001_2345_6789_AB00)) | EW'(i % 4));

      // sweep shifts, counts, indices and intents
      foreach (shs[s]) begin
         foreach (cnts[c]) begin
            set_cfg(shs[s], cnts[c]);
            chk(win_size == (EW'(m_cnt) << m_sh), "R9 window size", win_size, EW'(m_cnt) << m_sh);
            for (int k = 0; k < DEPTH + 2; k++) begin
               if ((k << shs[s]) < (1 << AW)) begin
                  logic [AW-1:0] a;
                  a = AW'((k << shs[s]) | ((k * 7 + 3) & ((1 << shs[s]) - 1)));
                  look(a, 1'b0, "R2 sweep read");
                  look(a, 1'b1, "R2 sweep write");
               end
            end
         end
      end

      // count above depth is clamped
      set_cfg(4, 15);
      chk(win_size == EW'(DEPTH << 4), "R8 count clamp", win_size, EW'(DEPTH << 4));
      look(16'h0075, 1'b0, "R8 last index in range after clamp");
      look(16'h0080, 1'b0, "R5 first index past clamp");
      look(16'hFFFF, 1'b1, "R5 top address");

      // same-cycle write and lookup of one index
      @(negedge clk);
      tw_en = 1'b1; tw_idx = 3'd2; tw_data = 64'h1111_2222_3333_4443;
      req_valid = 1'b1; req_addr = 16'h0025; req_write = 1'b1;
      @(negedge clk);
      tw_en = 1'b0; req_valid = 1'b0;
      chk(rsp_xaddr == (ent[2] & ~64'hF), "R11 old contents on collision", rsp_xaddr, ent[2] & ~64'hF);
      chk(rsp_perm == ent[2][1:0], "R11 old code on collision", EW'(rsp_perm), EW'(ent[2][1:0]));
      ent[2] = 64'h1111_2222_3333_4443;
      look(16'h0025, 1'b1, "R11 new contents next lookup");

      // reset again: all entries read zero, configuration back to defaults
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < DEPTH; i++) ent[i] = '0;
      m_sh = 12; m_cnt = DEPTH;
      chk(win_size == EW'(DEPTH << 12), "R8 defaults restored", win_size, EW'(DEPTH << 12));
      for (int i = 0; i < DEPTH; i++) look(AW'(i << 12), 1'b1, "R10 entry cleared by reset");

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule